// File: doc/BRIEF.md
# Flash Host Controller Register File

This block is the memory-mapped register file of a flash-storage host controller. Software reaches it over a plain 32-bit, word-only register bus with a byte address, write strobe, write data, read strobe and a registered read-data port. It holds the following registers:

- a read-only capability word and a read-only version word
- interrupt status and interrupt enable
- controller enable and controller status
- base addresses for the transfer list and the task list
- a run-stop word and a completion-notification word for the transfer list
- three argument words for link commands

A small command handler runs a link-layer command one clock after software writes its code to the command register. The handler updates controller status, the power-mode result field, argument word 2 and interrupt status. One level interrupt line is high while any enabled, maskable status bit is pending.

Transfer processing, doorbell execution and DMA are not part of this block. The physical link and power management are not part of it either. The doorbell and clear words of both lists accept writes, ignore them and read 0.

Top module: `flash_hc_regs`

## Requirements
- R1: After reset the version word (offset 0x08) reads 0x00000310. Every writable register, controller status and the interrupt line are 0.
- R2: A write to interrupt status (0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: The interrupt line is high exactly when (interrupt status AND 0x0007FFFF AND interrupt enable at 0x24) is nonzero. It follows every status, enable and command update.
- R4: Controller enable is bit 0 of 0x34.
  - Writing 1 while enable is 0 stores 1 and sets command-ready, bit 3 of controller status (0x30).
  - Writing 0 while enable is 1 stores 0 and zeroes controller status.
  - Writing the value enable already holds changes nothing.
- R5: Link startup (code 0x16 written to 0x90) sets these controller-status bits and writes 0 (success) into argument word 2 (0x98):
  - bit 0, device present
  - bit 1, transfer list ready
  - bit 2, task list ready
- R6: Hibernate enter (code 0x17) sets status bit 6. Hibernate exit (code 0x18) sets status bit 5. Both load value 1 (local success) into the power-mode result field, bits 10:8 of controller status, and write 0 into argument word 2.
- R7: Any other command code writes 1 (failure) into argument word 2. Every command, including an unknown one, sets the command-done status bit 10.
- R8: Command effects appear exactly one clock after the command write. A read on that clock still returns the old value. A bit the handler sets wins over a software clear of that bit on the same clock.
- R9: Base address storage and the completion word behave as follows:
  - Transfer list base low (0x50) and task list base low (0x70) keep only bits 31:10.
  - The high base words (0x54, 0x74), transfer run-stop (0x60) and the argument words are stored in full.
  - The completion word (0x64) clears bits written as 1, so it stays 0.
- R10: The doorbell and clear words (0x58, 0x5C, 0x78, 0x7C, 0x80) ignore writes and read 0. Reads at or above 0xA0 return 0. Writes at or above 0xA0 change no register, including a register at the same offset modulo 0x100.
- R11: Capability (0x00) holds these fields, with all other bits 0. With default parameters it reads 0x0107021F.
  - bits 4:0: transfer slots − 1
  - bits 15:8: the value 2
  - bits 18:16: task slots − 1
  - bit 24: 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the clock after bus_re |
| irq | output | 1 | Level interrupt |

## Verification
The bench writes a command and then reads interrupt status on the very next clock, and expects no done bit. A design that finished the command in the same cycle as the write would fail this check. It then lands a software clear on the clock the handler applies. A design that let the clear win would lose the done bit.

The enable checks cover three cases:
- a repeated 1 write, which must not disturb status a link command has built up
- a repeated 0 write after startup, which must not zero controller status
- a real falling edge, which must zero controller status

A write to 0x194 checks that decoding uses the full address. A design that dropped upper address bits would overwrite argument word 1.

// File: rtl/flash_hc_pkg.sv
package flash_hc_pkg;

  localparam int DATA_W = 32;

  localparam int OFS_CAP   = 'h00;
  localparam int OFS_VER   = 'h08;
  localparam int OFS_ISTAT = 'h20;
  localparam int OFS_IEN   = 'h24;
  localparam int OFS_CSTAT = 'h30;
  localparam int OFS_CEN   = 'h34;
  localparam int OFS_XLO   = 'h50;
  localparam int OFS_XHI   = 'h54;
  localparam int OFS_XDB   = 'h58;
  localparam int OFS_XCLR  = 'h5C;
  localparam int OFS_XRUN  = 'h60;
  localparam int OFS_XCMPL = 'h64;
  localparam int OFS_TLO   = 'h70;
  localparam int OFS_THI   = 'h74;
  localparam int OFS_TDB   = 'h78;
  localparam int OFS_TCLR  = 'h7C;
  localparam int OFS_TRUN  = 'h80;
  localparam int OFS_LCMD  = 'h90;
  localparam int OFS_ARG1  = 'h94;
  localparam int OFS_ARG2  = 'h98;
  localparam int OFS_ARG3  = 'h9C;
  localparam int REG_BYTES = 'hA0;

  localparam logic [31:0] VERSION_WORD = 32'h0000_0310;
  localparam logic [31:0] IRQ_MASK     = 32'h0007_FFFF;
  localparam logic [31:0] BASE_KEEP    = 32'hFFFF_FC00;

  localparam int IS_HIB_EXIT  = 5;
  localparam int IS_HIB_ENTER = 6;
  localparam int IS_CMD_DONE  = 10;

  localparam int CS_DEV_PRES = 0;
  localparam int CS_XL_RDY   = 1;
  localparam int CS_TL_RDY   = 2;
  localparam int CS_CMD_RDY  = 3;
  localparam int PMR_LSB     = 8;
  localparam int PMR_W       = 3;
  localparam logic [PMR_W-1:0] PMR_LOCAL = 3'd1;

  localparam logic [31:0] LC_STARTUP   = 32'h16;
  localparam logic [31:0] LC_HIB_ENTER = 32'h17;
  localparam logic [31:0] LC_HIB_EXIT  = 32'h18;
  localparam logic [31:0] RES_OK       = 32'd0;
  localparam logic [31:0] RES_FAIL     = 32'd1;

  typedef enum logic [1:0] {
    LK_STARTUP,
    LK_HIB_ENTER,
    LK_HIB_EXIT,
    LK_OTHER
  } lc_kind_e;

  function automatic lc_kind_e lc_classify(input logic [31:0] code);
    if (code == LC_STARTUP)        return LK_STARTUP;
    else if (code == LC_HIB_ENTER) return LK_HIB_ENTER;
    else if (code == LC_HIB_EXIT)  return LK_HIB_EXIT;
    else                           return LK_OTHER;
  endfunction

  function automatic logic [31:0] cap_word(input int xfer_slots, input int task_slots);
    logic [31:0] w;
    w        = '0;
    w[4:0]   = 5'(xfer_slots - 1);
    w[15:8]  = 8'd2;
    w[18:16] = 3'(task_slots - 1);
    w[24]    = 1'b1;
    return w;
  endfunction

  function automatic logic irq_level(input logic [31:0] stat, input logic [31:0] en);
    return |(stat & IRQ_MASK & en);
  endfunction

  function automatic logic [31:0] w1c(input logic [31:0] old, input logic [31:0] data);
    return old & ~data;
  endfunction

endpackage

// File: rtl/flash_hc_linkcmd.sv
module flash_hc_linkcmd
  import flash_hc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_code,
  output logic        apply,
  output logic [31:0] is_set,
  output logic [31:0] cs_set,
  output logic        pmr_load,
  output logic [31:0] arg2_res
);

  logic        pend_vld;
  logic [31:0] pend_code;
  lc_kind_e    kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_code <= '0;
    end else begin
      pend_vld <= cmd_wr;
      if (cmd_wr) pend_code <= cmd_code;
    end
  end

  assign apply = pend_vld;
  assign kind  = lc_classify(pend_code);

  always_comb begin
    is_set              = '0;
    cs_set              = '0;
    pmr_load            = 1'b0;
    arg2_res            = RES_OK;
    is_set[IS_CMD_DONE] = 1'b1;
    case (kind)
      LK_STARTUP: begin
        cs_set[CS_DEV_PRES] = 1'b1;
        cs_set[CS_XL_RDY]   = 1'b1;
        cs_set[CS_TL_RDY]   = 1'b1;
      end
      LK_HIB_ENTER: begin
        is_set[IS_HIB_ENTER] = 1'b1;
        pmr_load             = 1'b1;
      end
      LK_HIB_EXIT: begin
        is_set[IS_HIB_EXIT] = 1'b1;
        pmr_load            = 1'b1;
      end
      default: arg2_res = RES_FAIL;
    endcase
  end

  // R8
  cmd_apply_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> apply);

  // R8
  apply_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !apply);

endmodule

// File: rtl/flash_hc_irq.sv
module flash_hc_irq
  import flash_hc_pkg::*;
(
  input  logic [31:0] stat,
  input  logic [31:0] en,
  output logic        irq
);

  assign irq = irq_level(stat, en);

endmodule

// File: rtl/flash_hc_regs.sv
module flash_hc_regs
  import flash_hc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int XFER_SLOTS = 32,
  parameter int TASK_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq
);

  localparam logic [31:0] CAP_VAL = cap_word(XFER_SLOTS, TASK_SLOTS);

  if (XFER_SLOTS < 1 || XFER_SLOTS > 32 || TASK_SLOTS < 1 || TASK_SLOTS > 8) begin : g_param_bad
    $error("slot count parameter out of range");
  end

  logic [31:0] int_status, int_enable, ctl_status;
  logic        ctl_en;
  logic [31:0] xlo, xhi, xrun, xcmpl, tlo, thi;
  logic [31:0] arg1, arg2, arg3;

  logic        in_range;
  logic        wr_istat, wr_ien, wr_cen, wr_xlo, wr_xhi, wr_xrun, wr_xcmpl;
  logic        wr_tlo, wr_thi, wr_lcmd, wr_arg1, wr_arg2, wr_arg3;
  logic        en_rise, en_fall;

  logic        lc_apply, lc_pmr_load;
  logic [31:0] lc_is_set, lc_cs_set, lc_arg2;

  logic [31:0] is_next, cs_next, arg2_next, rd_val;

  assign in_range = (bus_addr < ADDR_W'(REG_BYTES));

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr_istat = bus_we && in_range && hit(bus_addr, OFS_ISTAT);
  assign wr_ien   = bus_we && in_range && hit(bus_addr, OFS_IEN);
  assign wr_cen   = bus_we && in_range && hit(bus_addr, OFS_CEN);
  assign wr_xlo   = bus_we && in_range && hit(bus_addr, OFS_XLO);
  assign wr_xhi   = bus_we && in_range && hit(bus_addr, OFS_XHI);
  assign wr_xrun  = bus_we && in_range && hit(bus_addr, OFS_XRUN);
  assign wr_xcmpl = bus_we && in_range && hit(bus_addr, OFS_XCMPL);
  assign wr_tlo   = bus_we && in_range && hit(bus_addr, OFS_TLO);
  assign wr_thi   = bus_we && in_range && hit(bus_addr, OFS_THI);
  assign wr_lcmd  = bus_we && in_range && hit(bus_addr, OFS_LCMD);
  assign wr_arg1  = bus_we && in_range && hit(bus_addr, OFS_ARG1);
  assign wr_arg2  = bus_we && in_range && hit(bus_addr, OFS_ARG2);
  assign wr_arg3  = bus_we && in_range && hit(bus_addr, OFS_ARG3);

  assign en_rise = wr_cen &&  bus_wdata[0] && !ctl_en;
  assign en_fall = wr_cen && !bus_wdata[0] &&  ctl_en;

  flash_hc_linkcmd u_linkcmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (wr_lcmd),
    .cmd_code (bus_wdata),
    .apply    (lc_apply),
    .is_set   (lc_is_set),
    .cs_set   (lc_cs_set),
    .pmr_load (lc_pmr_load),
    .arg2_res (lc_arg2)
  );

  flash_hc_irq u_irq (
    .stat (int_status),
    .en   (int_enable),
    .irq  (irq)
  );

  always_comb begin
    is_next = int_status;
    if (wr_istat) is_next = w1c(is_next, bus_wdata);
    if (lc_apply) is_next = is_next | lc_is_set;

    cs_next = ctl_status;
    if (en_rise) cs_next[CS_CMD_RDY] = 1'b1;
    if (en_fall) cs_next = '0;
    if (lc_apply) begin
      if (lc_pmr_load) cs_next[PMR_LSB +: PMR_W] = PMR_LOCAL;
      cs_next = cs_next | lc_cs_set;
    end

    arg2_next = arg2;
    if (wr_arg2)  arg2_next = bus_wdata;
    if (lc_apply) arg2_next = lc_arg2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_status <= '0;
      int_enable <= '0;
      ctl_status <= '0;
      ctl_en     <= 1'b0;
      xlo        <= '0;
      xhi        <= '0;
      xrun       <= '0;
      xcmpl      <= '0;
      tlo        <= '0;
      thi        <= '0;
      arg1       <= '0;
      arg2       <= '0;
      arg3       <= '0;
    end else begin
      int_status <= is_next;
      ctl_status <= cs_next;
      arg2       <= arg2_next;
      if (wr_ien)   int_enable <= bus_wdata;
      if (en_rise)  ctl_en     <= 1'b1;
      if (en_fall)  ctl_en     <= 1'b0;
      if (wr_xlo)   xlo        <= bus_wdata & BASE_KEEP;
      if (wr_xhi)   xhi        <= bus_wdata;
      if (wr_xrun)  xrun       <= bus_wdata;
      if (wr_xcmpl) xcmpl      <= w1c(xcmpl, bus_wdata);
      if (wr_tlo)   tlo        <= bus_wdata & BASE_KEEP;
      if (wr_thi)   thi        <= bus_wdata;
      if (wr_arg1)  arg1       <= bus_wdata;
      if (wr_arg3)  arg3       <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      case (int'(bus_addr))
        OFS_CAP:   rd_val = CAP_VAL;
        OFS_VER:   rd_val = VERSION_WORD;
        OFS_ISTAT: rd_val = int_status;
        OFS_IEN:   rd_val = int_enable;
        OFS_CSTAT: rd_val = ctl_status;
        OFS_CEN:   rd_val = {31'd0, ctl_en};
        OFS_XLO:   rd_val = xlo;
        OFS_XHI:   rd_val = xhi;
        OFS_XRUN:  rd_val = xrun;
        OFS_XCMPL: rd_val = xcmpl;
        OFS_TLO:   rd_val = tlo;
        OFS_THI:   rd_val = thi;
        OFS_ARG1:  rd_val = arg1;
        OFS_ARG2:  rd_val = arg2;
        OFS_ARG3:  rd_val = arg3;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  // R2
  istat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && !lc_apply) |=> ((int_status & $past(bus_wdata)) == 32'd0));

  // R3
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(int_status & IRQ_MASK & int_enable)));

  // R4
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (ctl_en && ctl_status[CS_CMD_RDY]));

  // R4
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !lc_apply) |=> (!ctl_en && ctl_status == 32'd0));

  // R7
  cmd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lc_apply |=> int_status[IS_CMD_DONE]);

  // R10
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !in_range) |=> bus_rdata == 32'd0);

endmodule

// File: tb/flash_hc_regs_tb.sv
module flash_hc_regs_tb;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  flash_hc_regs #(.ADDR_W(AW), .XFER_SLOTS(32), .TASK_SLOTS(8)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    bus_re = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // monitor: pops the expected value for each read as the data appears
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        #1;
        if (exp_q.size() == 0) begin
          check("monitor underflow", 32'd1, 32'd0);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  localparam logic [31:0] EXP_CAP = 32'(31) | (32'(2) << 8) | (32'(7) << 16) | (32'(1) << 24);

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();

    // R1 reset state, R11 capability fields
    rd('h08, 32'h0000_0310, "R1 version");
    rd('h20, 32'h0, "R1 istat");
    rd('h30, 32'h0, "R1 cstat");
    rd('h98, 32'h0, "R1 arg2");
    rd('h00, EXP_CAP, "R11 capability");
    check("R1 irq after reset", {31'd0, irq}, 32'd0);

    // R4 rising enable
    wr('h34, 32'h1);
    rd('h34, 32'h1, "R4 enable stored");
    rd('h30, 32'h8, "R4 command ready");

    // R5 link startup
    wr('h98, 32'h55);
    wr('h90, 32'h16);
    idle();
    rd('h30, 32'hF, "R5 cstat after startup");
    rd('h98, 32'h0, "R5 arg2 success");
    rd('h20, 32'h400, "R7 done bit after startup");
    wr('h34, 32'h1);
    rd('h30, 32'hF, "R4 repeated 1 has no effect");

    // R3 interrupt line
    check("R3 irq low with enable 0", {31'd0, irq}, 32'd0);
    wr('h24, 32'h400);
    check("R3 irq high", {31'd0, irq}, 32'd1);
    wr('h20, 32'h400);
    check("R3 irq low after clear", {31'd0, irq}, 32'd0);
    rd('h20, 32'h0, "R2 istat cleared");

    // R6 hibernate enter / exit
    wr('h90, 32'h17);
    idle();
    check("R3 irq after hib enter", {31'd0, irq}, 32'd1);
    rd('h20, 32'h440, "R6 hib enter status");
    rd('h30, 32'h10F, "R6 power-mode result");
    wr('h20, 32'h040);
    rd('h20, 32'h400, "R2 partial clear");
    wr('h20, 32'h400);
    wr('h90, 32'h18);
    idle();
    rd('h20, 32'h420, "R6 hib exit status");
    rd('h98, 32'h0, "R6 arg2 success");

    // R7 unknown command
    wr('h20, 32'hFFFF_FFFF);
    wr('h90, 32'h99);
    idle();
    rd('h98, 32'h1, "R7 arg2 failure");
    rd('h20, 32'h400, "R7 done bit on unknown");

    // R8 timing and priority
    wr('h20, 32'hFFFF_FFFF);
    wr('h90, 32'h16);
    rd('h20, 32'h0, "R8 not yet applied");
    rd('h20, 32'h400, "R8 applied next clock");
    wr('h20, 32'hFFFF_FFFF);
    wr('h90, 32'h99);
    wr('h20, 32'h400);
    rd('h20, 32'h400, "R8 set beats clear");

    // R4 falling enable
    wr('h34, 32'h0);
    rd('h30, 32'h0, "R4 cstat wiped");
    rd('h34, 32'h0, "R4 enable cleared");
    wr('h90, 32'h16);
    idle();
    wr('h34, 32'h0);
    rd('h30, 32'h7, "R4 repeated 0 has no effect");

    // R9 storage masks
    wr('h50, 32'hFFFF_FFFF);
    rd('h50, 32'hFFFF_FC00, "R9 xfer base low mask");
    wr('h54, 32'hFFFF_FFFF);
    rd('h54, 32'hFFFF_FFFF, "R9 xfer base high");
    wr('h70, 32'h1234_5678);
    rd('h70, 32'h1234_5400, "R9 task base low mask");
    wr('h74, 32'hCAFE_0001);
    rd('h74, 32'hCAFE_0001, "R9 task base high");
    wr('h60, 32'hA5);
    rd('h60, 32'hA5, "R9 run-stop");
    wr('h64, 32'hFFFF_FFFF);
    rd('h64, 32'h0, "R9 completion stays 0");

    // R10 ignored and out-of-range
    wr('h58, 32'hFFFF_FFFF);
    rd('h58, 32'h0, "R10 doorbell ignored");
    wr('h78, 32'hFFFF_FFFF);
    rd('h78, 32'h0, "R10 task doorbell ignored");
    rd('hA0, 32'h0, "R10 read past end");
    rd('hFFC, 32'h0, "R10 read far past end");
    wr('h94, 32'h1111);
    wr('h194, 32'h2222);
    rd('h94, 32'h1111, "R10 write past end ignored");

    // R3 enable gating with pending status
    wr('h24, 32'h0);
    check("R3 irq low when disabled", {31'd0, irq}, 32'd0);

    repeat (3) idle();
    if (exp_q.size() != 0) check("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule